// File: doc/BRIEF.md
# Byte-Wide Card Bus Host Controller

This block is the host end of a byte-wide, SPI-like link to a removable card. A local agent hands it a 16-byte command, a response length and a busy-wait limit in a single request cycle. The block lowers the active-low select line and puts one command byte on the 8-bit bus each clock, followed by a CRC-32 of the command. It then releases the bus for a two-cycle turnaround and reads a one-byte status from the card.

If the card accepts the command, the host keeps clocking while the card signals busy on data bit 0. It watches for the card's ready marker, which is bit 0 high on two consecutive samples. It then collects the programmed number of response bytes and checks the 4-byte CRC-32 that follows them. The block raises select again, reports the transfer with a one-cycle done pulse and at most one error flag, and becomes ready for the next request.

The pad is modelled with a separate output byte, a shared output enable and an input byte. The block clock is the bus clock: outputs change after a rising edge, and the bus input is sampled on the rising edge.

Top module: `cardbus_host`

## Requirements
- R1: While reset is high, and in idle afterwards, `bus_cs_n` is 1, `bus_oe` is 0, `req_ready` is 1 and `done` is 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. From the next cycle, `bus_cs_n` is 0, `bus_oe` is 1, and byte i of the command (`req_cmd[8i+7:8i]`, i = 0..15) appears on `bus_dout` in cycle i, one byte per cycle.
- R3: The 16 command bytes are followed directly by 4 CRC bytes with `bus_oe` still 1. The CRC is the reflected CRC-32 with polynomial 0x04C11DB7, initial value 0xFFFFFFFF and final XOR 0xFFFFFFFF, and it is sent least significant byte first. The bus is never driven while select is high.
- R4: After the CRC, `bus_oe` is 0 for two turnaround cycles with select still low. The status byte is sampled at the end of the third undriven cycle.
- R5: A status of 0x01, or any other non-zero value, ends the transfer. The next cycle is the done cycle with `err_status` set, and no response bytes are delivered.
- R6: After a zero status, bit 0 of `bus_din` is sampled once per cycle. The card is ready when two consecutive samples are 1. A single 1 between zeros does not count. Response byte 0 is sampled at the end of the cycle after the second high sample.
- R7: Exactly `req_len` response bytes (0 to 512) are sampled, one per cycle. Each appears on `rsp_data` with `rsp_valid` high in the cycle after it is sampled. The bus is not driven while `rsp_valid` is high.
- R8: The response bytes are followed by 4 CRC bytes over the response data, in the CRC-32 form of R3, least significant byte first. A mismatch sets `err_crc` in the done cycle, and a match leaves all error flags clear. With `req_len` = 0 the expected CRC is 0x00000000.
- R9: The busy samples are numbered from 0. If the ready marker has not completed by sample number `busy_limit`, the done cycle follows that sample with `err_timeout` set. A marker that completes exactly on sample `busy_limit` is accepted.
- R10: `done` is high for exactly one cycle with `bus_cs_n` high. At most one error flag is set in that cycle, and `req_ready` returns to 1 in the following cycle.
- R11: `req_valid` pulses with other command, length or limit values while a transfer is in progress have no effect on the bytes driven, the response length or the outcome of that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; bus input sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_ready | output | 1 | Block is idle and will accept a request |
| req_cmd | input | 128 | Command, byte i in bits 8i+7:8i, byte 0 sent first |
| req_len | input | 10 | Number of response data bytes, 0 to 512 |
| busy_limit | input | 16 | Highest busy sample number allowed for the ready marker |
| bus_cs_n | output | 1 | Active-low card select |
| bus_dout | output | 8 | Byte driven toward the pad |
| bus_oe | output | 1 | Pad output enable for all eight data lines |
| bus_din | input | 8 | Byte read from the pad |
| rsp_valid | output | 1 | One response data byte is present on `rsp_data` |
| rsp_data | output | 8 | Response data byte |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err_status | output | 1 | Card rejected the command, valid with `done` |
| err_crc | output | 1 | Response CRC mismatch, valid with `done` |
| err_timeout | output | 1 | Ready marker did not arrive in time, valid with `done` |

## Verification
The hardest behaviour to reach from the ports is the ready marker at the edge of the busy window. One case completes the marker exactly on sample `busy_limit`, which must be accepted. In the other, the first high sample lands on `busy_limit`, which must time out. A lone high sample between busy zeros must also be rejected. The bench's card model drives bit 0 of `bus_din` from a per-cycle schedule built for each case: a chosen number of low samples, an optional lone high in the middle, then the two-sample marker. The expected trace, including the cycle of the done pulse and which flag is set, is derived from that same schedule by walking the protocol rules.

// File: rtl/cbh_pkg.sv
package cbh_pkg;

    localparam int          CRC_BYTES  = 4;
    localparam logic [31:0] CRC_POLY   = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_SEED   = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_XOROUT = 32'hFFFF_FFFF;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD,
        ST_CCRC,
        ST_TURN,
        ST_STAT,
        ST_BUSY,
        ST_RESP,
        ST_RCRC,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic rejected;
        logic bad_crc;
        logic timed_out;
    } xfer_flags_t;

    function automatic logic [31:0] bit_reverse32(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) begin
            r[i] = v[31-i];
        end
        return r;
    endfunction

    // One byte through the reflected CRC-32 register, LSB of the byte first.
    function automatic logic [31:0] crc32_step(input logic [31:0] cur, input logic [7:0] b);
        logic [31:0] c;
        logic [31:0] p;
        logic        fb;
        c = cur;
        p = bit_reverse32(CRC_POLY);
        for (int i = 0; i < 8; i++) begin
            fb = c[0] ^ b[i];
            c  = c >> 1;
            if (fb) begin
                c = c ^ p;
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/cbh_crc32.sv
module cbh_crc32
    import cbh_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        en,
    input  logic [7:0]  data,
    output logic [31:0] crc_out
);

    logic [31:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc_q <= CRC_SEED;
        end else if (en) begin
            acc_q <= crc32_step(acc_q, data);
        end
    end

    assign crc_out = acc_q ^ CRC_XOROUT;

endmodule

// File: rtl/cbh_tx_mux.sv
module cbh_tx_mux
    import cbh_pkg::*;
#(
    parameter int CMD_BYTES = 16,
    parameter int CI_W      = $clog2(CMD_BYTES)
) (
    input  logic [CMD_BYTES*8-1:0] cmd,
    input  logic [31:0]            crc,
    input  logic [CI_W-1:0]        idx,
    input  logic                   sel_cmd,
    input  logic                   sel_crc,
    output logic [7:0]             dout
);

    logic [7:0] cmd_b [CMD_BYTES];
    logic [7:0] crc_b [CRC_BYTES];

    for (genvar g = 0; g < CMD_BYTES; g++) begin : g_cmd
        assign cmd_b[g] = cmd[g*8 +: 8];
    end

    for (genvar g = 0; g < CRC_BYTES; g++) begin : g_crc
        assign crc_b[g] = crc[g*8 +: 8];
    end

    always_comb begin
        dout = 8'h00;
        if (sel_cmd) begin
            dout = cmd_b[idx];
        end else if (sel_crc) begin
            dout = crc_b[idx[1:0]];
        end
    end

endmodule

// File: rtl/cbh_ready_det.sv
module cbh_ready_det #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             din0,
    input  logic [TMO_W-1:0] limit,
    output logic             ready,
    output logic             timeout
);

    logic [TMO_W-1:0] cnt_q;
    logic             seen_q;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_q + TMO_W'(1);
            seen_q <= din0;
        end
    end

    assign ready   = active && din0 && seen_q;
    assign timeout = active && !ready && (cnt_q == limit);

    AST_READY_AFTER_HIGH: assert property (@(posedge clk) disable iff (rst)
        ready |-> $past(din0));                                  // R6
    AST_READY_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        ready |-> $past(active));                                // R6

endmodule

// File: rtl/cardbus_host.sv
module cardbus_host
    import cbh_pkg::*;
#(
    parameter int CMD_BYTES   = 16,
    parameter int TURN_CYCLES = 2,
    parameter int MAX_RESP    = 512,
    parameter int TMO_W       = 16,
    parameter int LEN_W       = $clog2(MAX_RESP + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [CMD_BYTES*8-1:0] req_cmd,
    input  logic [LEN_W-1:0]       req_len,
    input  logic [TMO_W-1:0]       busy_limit,
    output logic                   bus_cs_n,
    output logic [7:0]             bus_dout,
    output logic                   bus_oe,
    input  logic [7:0]             bus_din,
    output logic                   rsp_valid,
    output logic [7:0]             rsp_data,
    output logic                   done,
    output logic                   err_status,
    output logic                   err_crc,
    output logic                   err_timeout
);

    localparam int CI_W  = $clog2(CMD_BYTES);
    localparam int IDX_W = (LEN_W > CI_W) ? LEN_W : CI_W;

    seq_state_e             state;
    logic [IDX_W-1:0]       idx_q;
    logic [CMD_BYTES*8-1:0] cmd_q;
    logic [LEN_W-1:0]       len_q;
    logic [TMO_W-1:0]       lim_q;
    xfer_flags_t            flags_q;
    logic                   rsp_valid_q;
    logic [7:0]             rsp_data_q;
    logic [23:0]            rxc_q;

    logic [31:0] tx_crc;
    logic [31:0] rx_crc;
    logic        drive_cmd;
    logic        drive_crc;
    logic        busy_ready;
    logic        busy_timeout;
    logic        idle;

    assign idle      = (state == ST_IDLE);
    assign drive_cmd = (state == ST_CMD);
    assign drive_crc = (state == ST_CCRC);

    cbh_tx_mux #(
        .CMD_BYTES (CMD_BYTES),
        .CI_W      (CI_W)
    ) u_tx_mux (
        .cmd     (cmd_q),
        .crc     (tx_crc),
        .idx     (idx_q[CI_W-1:0]),
        .sel_cmd (drive_cmd),
        .sel_crc (drive_crc),
        .dout    (bus_dout)
    );

    cbh_crc32 u_tx_crc (
        .clk     (clk),
        .rst     (rst),
        .clear   (idle),
        .en      (drive_cmd),
        .data    (bus_dout),
        .crc_out (tx_crc)
    );

    cbh_crc32 u_rx_crc (
        .clk     (clk),
        .rst     (rst),
        .clear   (idle),
        .en      (state == ST_RESP),
        .data    (bus_din),
        .crc_out (rx_crc)
    );

    cbh_ready_det #(
        .TMO_W (TMO_W)
    ) u_ready (
        .clk     (clk),
        .rst     (rst),
        .active  (state == ST_BUSY),
        .din0    (bus_din[0]),
        .limit   (lim_q),
        .ready   (busy_ready),
        .timeout (busy_timeout)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            idx_q       <= '0;
            cmd_q       <= '0;
            len_q       <= '0;
            lim_q       <= '0;
            flags_q     <= '0;
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
            rxc_q       <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        cmd_q   <= req_cmd;
                        len_q   <= req_len;
                        lim_q   <= busy_limit;
                        flags_q <= '0;
                        idx_q   <= '0;
                        state   <= ST_CMD;
                    end
                end
                ST_CMD: begin
                    if (idx_q == IDX_W'(CMD_BYTES - 1)) begin
                        idx_q <= '0;
                        state <= ST_CCRC;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                ST_CCRC: begin
                    if (idx_q == IDX_W'(CRC_BYTES - 1)) begin
                        idx_q <= '0;
                        state <= ST_TURN;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                ST_TURN: begin
                    if (idx_q == IDX_W'(TURN_CYCLES - 1)) begin
                        idx_q <= '0;
                        state <= ST_STAT;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                ST_STAT: begin
                    if (bus_din != 8'h00) begin
                        flags_q.rejected <= 1'b1;
                        state            <= ST_DONE;
                    end else begin
                        state <= ST_BUSY;
                    end
                end
                ST_BUSY: begin
                    if (busy_ready) begin
                        idx_q <= '0;
                        state <= (len_q == '0) ? ST_RCRC : ST_RESP;
                    end else if (busy_timeout) begin
                        flags_q.timed_out <= 1'b1;
                        state             <= ST_DONE;
                    end
                end
                ST_RESP: begin
                    rsp_valid_q <= 1'b1;
                    rsp_data_q  <= bus_din;
                    if (idx_q == IDX_W'(len_q - LEN_W'(1))) begin
                        idx_q <= '0;
                        state <= ST_RCRC;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                ST_RCRC: begin
                    rxc_q <= {bus_din, rxc_q[23:8]};
                    if (idx_q == IDX_W'(CRC_BYTES - 1)) begin
                        flags_q.bad_crc <= ({bus_din, rxc_q} != rx_crc);
                        idx_q           <= '0;
                        state           <= ST_DONE;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                ST_DONE: begin
                    state <= ST_IDLE;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    assign req_ready   = idle;
    assign bus_cs_n    = idle || (state == ST_DONE);
    assign bus_oe      = drive_cmd || drive_crc;
    assign rsp_valid   = rsp_valid_q;
    assign rsp_data    = rsp_data_q;
    assign done        = (state == ST_DONE);
    assign err_status  = flags_q.rejected;
    assign err_crc     = flags_q.bad_crc;
    assign err_timeout = flags_q.timed_out;

    AST_DRIVE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> !bus_cs_n);                                   // R3
    AST_RSP_BUS_RELEASED: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !bus_oe);                                  // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                         // R10
    AST_DONE_DESELECT: assert property (@(posedge clk) disable iff (rst)
        done |-> bus_cs_n);                                      // R10
    AST_ONE_ERROR: assert property (@(posedge clk) disable iff (rst)
        done |-> ($countones({err_status, err_crc, err_timeout}) <= 1)); // R10
    AST_DONE_THEN_READY: assert property (@(posedge clk) disable iff (rst)
        done |=> req_ready);                                     // R10
    AST_REQ_IGNORED_LEN: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> $stable(len_q));                          // R11
    AST_REQ_IGNORED_CMD: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> $stable(cmd_q));                          // R11

endmodule

// File: tb/tb_cardbus_host.sv
module tb_cardbus_host;

    localparam int LEN_W = 10;
    localparam int TMO_W = 16;
    localparam int MAXS  = 2048;

    logic               clk = 1'b0;
    logic               rst;
    logic               req_valid;
    logic               req_ready;
    logic [127:0]       req_cmd;
    logic [LEN_W-1:0]   req_len;
    logic [TMO_W-1:0]   busy_limit;
    logic               bus_cs_n;
    logic [7:0]         bus_dout;
    logic               bus_oe;
    logic [7:0]         bus_din;
    logic               rsp_valid;
    logic [7:0]         rsp_data;
    logic               done;
    logic               err_status;
    logic               err_crc;
    logic               err_timeout;

    always #4 clk = ~clk;

    cardbus_host dut (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_cmd     (req_cmd),
        .req_len     (req_len),
        .busy_limit  (busy_limit),
        .bus_cs_n    (bus_cs_n),
        .bus_dout    (bus_dout),
        .bus_oe      (bus_oe),
        .bus_din     (bus_din),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data),
        .done        (done),
        .err_status  (err_status),
        .err_crc     (err_crc),
        .err_timeout (err_timeout)
    );

    int total = 0;
    int bad   = 0;

    // Expected per-cycle trace; slot 0 is the cycle after the accepting edge.
    logic       exp_cs   [MAXS];
    logic       exp_oe   [MAXS];
    logic [7:0] exp_dout [MAXS];
    logic       exp_rv   [MAXS];
    logic [7:0] exp_rd   [MAXS];
    logic       exp_done [MAXS];
    logic [7:0] din_s    [MAXS];
    string      tag_s    [MAXS];
    logic [2:0] exp_fl;
    int         nslots;
    int         done_slot;

    function automatic logic [31:0] ref_crc(input logic [7:0] b[$]);
        logic [31:0] c;
        logic        fb;
        c = 32'hFFFF_FFFF;
        foreach (b[i]) begin
            for (int k = 0; k < 8; k++) begin
                fb = c[0] ^ b[i][k];
                c  = c >> 1;
                if (fb) c = c ^ 32'hEDB8_8320;
            end
        end
        return ~c;
    endfunction

    task automatic check(input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h (t=%0t)", rq, what, act, exp, $time);
        end
    endtask

    function automatic logic busy_bit(input int j, input int lows, input bit glitch, input bit never);
        if (never) return 1'b0;
        if (j < lows) return (glitch && j == lows / 2) ? 1'b1 : 1'b0;
        return 1'b1;
    endfunction

    task automatic build(input logic [127:0] cmd, input int len, input int limit,
                         input logic [7:0] status, input int lows, input bit glitch,
                         input bit never, input bit corrupt);
        logic [7:0]  cq[$];
        logic [7:0]  rq[$];
        logic [31:0] c;
        int          r;
        int          s;
        logic        seen;
        logic        b;
        for (int i = 0; i < MAXS; i++) begin
            exp_cs[i] = 1'b1; exp_oe[i] = 1'b0; exp_dout[i] = 8'h00;
            exp_rv[i] = 1'b0; exp_rd[i] = 8'h00; exp_done[i] = 1'b0;
            din_s[i] = 8'hFF; tag_s[i] = "R10";
        end
        exp_fl = 3'b000;
        for (int i = 0; i < 16; i++) begin
            cq.push_back(cmd[i*8 +: 8]);
            exp_cs[i] = 1'b0; exp_oe[i] = 1'b1; exp_dout[i] = cmd[i*8 +: 8]; tag_s[i] = "R2";
        end
        c = ref_crc(cq);
        for (int i = 0; i < 4; i++) begin
            exp_cs[16+i] = 1'b0; exp_oe[16+i] = 1'b1; exp_dout[16+i] = c[i*8 +: 8]; tag_s[16+i] = "R3";
        end
        for (int i = 20; i < 23; i++) begin
            exp_cs[i] = 1'b0; tag_s[i] = "R4";
        end
        din_s[22] = status;
        if (status != 8'h00) begin
            done_slot = 23; exp_done[23] = 1'b1; exp_fl = 3'b100; tag_s[23] = "R5";
            nslots = 25;
            return;
        end
        seen = 1'b0;
        r = -1;
        for (int j = 0; r < 0; j++) begin
            s = 23 + j;
            b = busy_bit(j, lows, glitch, never);
            din_s[s] = {7'h29, b};
            exp_cs[s] = 1'b0; tag_s[s] = "R6";
            if (b && seen) begin
                r = s;
            end else if (j == limit) begin
                tag_s[s] = "R9";
                done_slot = s + 1; exp_done[s+1] = 1'b1; exp_fl = 3'b001; tag_s[s+1] = "R9";
                nslots = s + 3;
                return;
            end else begin
                seen = b;
            end
        end
        for (int i = 0; i < len; i++) begin
            rq.push_back(8'(i * 37 + int'(cmd[7:0])));
            din_s[r+1+i] = rq[i];
            exp_cs[r+1+i] = 1'b0; tag_s[r+1+i] = "R7";
            exp_rv[r+2+i] = 1'b1; exp_rd[r+2+i] = rq[i];
        end
        c = ref_crc(rq);
        if (corrupt) c[23:16] = c[23:16] ^ 8'h01;
        for (int i = 0; i < 4; i++) begin
            din_s[r+len+1+i] = c[i*8 +: 8];
            exp_cs[r+len+1+i] = 1'b0; tag_s[r+len+1+i] = "R8";
        end
        done_slot = r + len + 5;
        exp_done[done_slot] = 1'b1;
        exp_fl = corrupt ? 3'b010 : 3'b000;
        tag_s[done_slot] = "R8";
        nslots = done_slot + 2;
    endtask

    task automatic run(input logic [127:0] cmd, input int len, input int limit,
                       input logic [7:0] status, input int lows, input bit glitch,
                       input bit never, input bit corrupt, input bit junk);
        build(cmd, len, limit, status, lows, glitch, never, corrupt);
        @(negedge clk);
        req_cmd    = cmd;
        req_len    = LEN_W'(len);
        busy_limit = TMO_W'(limit);
        req_valid  = 1'b1;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        for (int k = 0; k < nslots; k++) begin
            bus_din = din_s[k];
            if (junk && k < done_slot) begin
                // R11: foreign requests during the transfer
                req_valid  = 1'b1;
                req_cmd    = ~cmd;
                req_len    = LEN_W'(len + 3);
                busy_limit = 16'd0;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
            check(junk ? "R11" : tag_s[k], "cs_n", 32'(bus_cs_n), 32'(exp_cs[k]));
            check(junk ? "R11" : tag_s[k], "oe", 32'(bus_oe), 32'(exp_oe[k]));
            if (exp_oe[k]) check(junk ? "R11" : tag_s[k], "dout", 32'(bus_dout), 32'(exp_dout[k]));
            check("R7", "rsp_valid", 32'(rsp_valid), 32'(exp_rv[k]));
            if (exp_rv[k]) check("R7", "rsp_data", 32'(rsp_data), 32'(exp_rd[k]));
            check("R10", "done", 32'(done), 32'(exp_done[k]));
            check("R10", "req_ready", 32'(req_ready), 32'(k > done_slot));
            if (exp_done[k]) begin
                check(junk ? "R11" : tag_s[k], "flags", 32'({err_status, err_crc, err_timeout}), 32'(exp_fl));
            end
            @(posedge clk);
            #1;
        end
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: run did not finish actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_cmd = '0; req_len = '0;
        busy_limit = '0; bus_din = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state under reset
        check("R1", "cs_n", 32'(bus_cs_n), 32'd1);
        check("R1", "oe", 32'(bus_oe), 32'd0);
        check("R1", "req_ready", 32'(req_ready), 32'd1);
        check("R1", "done", 32'(done), 32'd0);
        rst = 1'b0;
        @(posedge clk);
        #1;
        @(negedge clk);
        // R1: idle after reset
        check("R1", "cs_n idle", 32'(bus_cs_n), 32'd1);
        check("R1", "req_ready idle", 32'(req_ready), 32'd1);
        @(posedge clk);
        #1;

        // R2 R3 R4 R6 R7 R8: plain read of 4 bytes
        run(128'h0F0E0D0C_0B0A0908_07060504_03020100, 4, 20, 8'h00, 3, 1'b0, 1'b0, 1'b0, 1'b0);
        // R5: command CRC rejected
        run(128'h11111111_22222222_33333333_5B000000, 4, 20, 8'h01, 0, 1'b0, 1'b0, 1'b0, 1'b0);
        // R5: other non-zero status
        run(128'hDEADBEEF_00000000_CAFEF00D_56000000, 4, 20, 8'h5A, 0, 1'b0, 1'b0, 1'b0, 1'b0);
        // R6: lone high sample in the busy phase does not count
        run(128'h01234567_89ABCDEF_FEDCBA98_76543210, 8, 30, 8'h00, 6, 1'b1, 1'b0, 1'b0, 1'b0);
        // R9: marker completes exactly on sample busy_limit
        run(128'hA5A5A5A5_5A5A5A5A_00FF00FF_28000000, 4, 5, 8'h00, 4, 1'b0, 1'b0, 1'b0, 1'b0);
        // R9: first high lands on busy_limit, times out
        run(128'hA5A5A5A5_5A5A5A5A_00FF00FF_28000001, 4, 5, 8'h00, 5, 1'b0, 1'b0, 1'b0, 1'b0);
        // R9: card never ready
        run(128'h13579BDF_2468ACE0_0F1E2D3C_E2000000, 4, 40, 8'h00, 0, 1'b0, 1'b1, 1'b0, 1'b0);
        // R8: corrupted response CRC
        run(128'h00000000_00000000_00000000_E0000000, 16, 20, 8'h00, 2, 1'b0, 1'b0, 1'b1, 1'b0);
        // R7 R8: zero-length response
        run(128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF, 0, 20, 8'h00, 1, 1'b0, 1'b0, 1'b0, 1'b0);
        // R7: full 512-byte response
        run(128'h00000000_00000000_00000100_0000005B, 512, 20, 8'h00, 1, 1'b0, 1'b0, 1'b0, 1'b0);
        // R11: requests while busy are ignored
        run(128'h89ABCDEF_01234567_76543210_FEDCBA98, 6, 20, 8'h00, 2, 1'b0, 1'b0, 1'b0, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule